// File: doc/BRIEF.md
# Bus-Serviced Watchdog Reset Supervisor

This block produces a single system reset from two conditions: a supply-OK flag from an external comparator, and a watchdog timer. The watchdog has no dedicated kick pin. The host services it through ordinary two-wire serial bus activity. SDA has to fall, then SCL has to fall from high to low, and then a stop condition has to follow, with SDA rising while SCL is high. Only that complete sequence restarts the watchdog count. A write-protect input freezes the timeout selection. Every interval is a parameterized number of clock cycles, so the same RTL serves both silicon timing and short simulations.

A low supply-OK flag asserts reset at once, without waiting for a clock edge. It also clears every register in the block asynchronously. Reset is released only after a fixed hold interval of `HOLD_CYCLES` clocks with supply-OK high, and this covers power-up as well. A watchdog expiry asserts reset for the same hold interval. When the hold interval ends, the watchdog count starts again from zero.

The controller is a state machine with three states:

- `ST_SUPPLY_HOLD`: supply recovery or power-up.
- `ST_RUN`: reset released.
- `ST_WDT_HOLD`: reset after a watchdog expiry.

Its transitions are:

- `T_SUPPLY_DONE`: `ST_SUPPLY_HOLD` to `ST_RUN` when the hold count completes.
- `T_EXPIRE`: `ST_RUN` to `ST_WDT_HOLD` when the enabled watchdog count reaches the limit.
- `T_WDT_DONE`: `ST_WDT_HOLD` to `ST_RUN` when the hold count completes.
- `T_SUPPLY_FAIL`: any state to `ST_SUPPLY_HOLD`, asynchronously, when supply-OK falls.

The service detector is a second state machine with three states: `SQ_IDLE`, `SQ_ARMED` and `SQ_WAIT_STOP`. Its transitions are:

- `SQ_IDLE` to `SQ_ARMED` on an SDA fall.
- `SQ_ARMED` to `SQ_WAIT_STOP` on an SCL fall.
- `SQ_ARMED` back to `SQ_IDLE` on a stop that arrives before any SCL fall.
- `SQ_WAIT_STOP` to `SQ_IDLE` on a stop, which emits one service pulse.

Top module: `bus_wdt_supervisor`

## Requirements
- R1: While `supply_ok` is low, reset is asserted, and it asserts in the same instant that `supply_ok` falls, with no clock edge needed.
- R2: After `supply_ok` rises, including at power-up, reset stays asserted for `HOLD_CYCLES` clock cycles and then releases.
- R3: While `wdt_en` is low, the watchdog never asserts reset, however long the bus stays idle.
- R4: While `wdt_en` is high and no service sequence completes, reset asserts after the selected timeout. The timeout is `TMO_BASE << (sel*TMO_SHIFT)` cycles: with the defaults, selection 0 gives 64, 1 gives 128, 2 gives 256 and 3 gives 512. The selection resets to `DEF_SEL`, which is 0 by default.
- R5: A complete service sequence restarts the watchdog count from zero. The sequence is an SDA fall, then an SCL high-to-low transition, then SDA rising while SCL is high.
- R6: A partial sequence does not restart the count. Two examples are a start that is followed by a stop with no SCL fall, and a start with an SCL fall but no stop.
- R7: While `wp` is high, a `tmo_load` pulse leaves the timeout selection unchanged.
- R8: A watchdog expiry holds reset for `HOLD_CYCLES` cycles. After release, the watchdog count restarts from zero, so a second unserviced timeout expires one full timeout later.
- R9: When `RST_ACTIVE_LOW` is 1, `rst_out` is 0 while reset is active. When it is 0, `rst_out` is 1 while reset is active.
- R10: A `tmo_load` pulse with `wp` low replaces the timeout selection with `tmo_sel`, and the new timeout applies from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| supply_ok | input | 1 | High when the supply is above its sense level; low acts as an asynchronous clear |
| sda_in | input | 1 | Sampled serial data line (asynchronous) |
| scl_in | input | 1 | Sampled serial clock line (asynchronous) |
| wp | input | 1 | Write-protect; high blocks timeout-selection loads |
| wdt_en | input | 1 | Watchdog enable |
| tmo_sel | input | SEL_W | Timeout selection value to load |
| tmo_load | input | 1 | One-cycle strobe that loads `tmo_sel` |
| rst_out | output | 1 | Reset output, with polarity set by `RST_ACTIVE_LOW` |

## Verification
The assertions take for granted that every SDA and SCL level is held for longer than the synchronizer depth. This ensures each bus edge reaches the detector as one clean transition. They also take for granted that `supply_ok` is the only source of clearing, so each property is disabled while it is low. The stimulus changes every input on the falling clock edge and holds each bus level for four cycles. It pulses `tmo_load` for exactly one cycle. It keeps the service interval well below the shortest timeout, except where an expiry is the point of the test.

// File: rtl/bwd_pkg.sv
`timescale 1ns/1ps
package bwd_pkg;

    typedef enum logic [1:0] {
        ST_SUPPLY_HOLD = 2'd0,
        ST_RUN         = 2'd1,
        ST_WDT_HOLD    = 2'd2
    } ctrl_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE      = 2'd0,
        SQ_ARMED     = 2'd1,
        SQ_WAIT_STOP = 2'd2
    } seq_state_e;

endpackage

// File: rtl/bwd_sync.sv
`timescale 1ns/1ps
module bwd_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg[0] <= RST_VAL;
        else         stg[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) stg[s] <= RST_VAL;
                else         stg[s] <= stg[s-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bwd_seq_detect.sv
`timescale 1ns/1ps
module bwd_seq_detect
    import bwd_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic sda_s,
    input  logic scl_s,
    output logic svc
);
    seq_state_e state_q, state_d;
    logic sda_prev, scl_prev;
    logic sda_fall, sda_rise, scl_fall, stop_seen;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            sda_prev <= 1'b1;
            scl_prev <= 1'b1;
        end else begin
            sda_prev <= sda_s;
            scl_prev <= scl_s;
        end
    end

    assign sda_fall  = sda_prev & ~sda_s;
    assign sda_rise  = ~sda_prev & sda_s;
    assign scl_fall  = scl_prev & ~scl_s;
    assign stop_seen = sda_rise & scl_s;

    // State register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= SQ_IDLE;
        else         state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:      if (sda_fall) state_d = SQ_ARMED;
            SQ_ARMED: begin
                if (scl_fall)       state_d = SQ_WAIT_STOP;
                else if (stop_seen) state_d = SQ_IDLE;
            end
            SQ_WAIT_STOP: if (stop_seen) state_d = SQ_IDLE;
            default:      state_d = SQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        svc = 1'b0;
        unique case (state_q)
            SQ_WAIT_STOP: svc = stop_seen;
            default:      svc = 1'b0;
        endcase
    end

    p_svc_returns_idle_r5: assert property (@(posedge clk) disable iff (!arst_n)
        svc |=> (state_q == SQ_IDLE));

    p_armed_from_idle_fall_r6: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == SQ_WAIT_STOP) && ($past(state_q) != SQ_WAIT_STOP)
        |-> ($past(state_q) == SQ_ARMED));
endmodule

// File: rtl/bwd_ctrl.sv
`timescale 1ns/1ps
module bwd_ctrl
    import bwd_pkg::*;
#(
    parameter int HOLD_CYCLES = 40,
    parameter int TMO_BASE    = 64,
    parameter int TMO_SHIFT   = 1,
    parameter int SEL_W       = 2,
    parameter int DEF_SEL     = 0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             wdt_en,
    input  logic             wp,
    input  logic             sel_load,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             svc,
    output logic             rst_active
);
    localparam int NSEL    = 1 << SEL_W;
    localparam int MAX_TMO = TMO_BASE << ((NSEL-1) * TMO_SHIFT);
    localparam int CW      = $clog2(MAX_TMO + 1);
    localparam int HW      = $clog2(HOLD_CYCLES + 1);

    ctrl_state_e      state_q, state_d;
    logic [SEL_W-1:0] sel_q;
    logic [CW-1:0]    wdt_cnt_q;
    logic [HW-1:0]    hold_cnt_q;
    logic [CW-1:0]    limit_tbl [NSEL];
    logic [CW-1:0]    limit;
    logic             expire, hold_done;

    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_limit
            localparam int unsigned LIM = TMO_BASE << (g * TMO_SHIFT);
            assign limit_tbl[g] = CW'(LIM);
        end
    endgenerate

    assign limit     = limit_tbl[sel_q];
    assign expire    = wdt_en && (wdt_cnt_q >= limit - CW'(1));
    assign hold_done = (hold_cnt_q == HW'(HOLD_CYCLES - 1));

    // Timeout selection register, locked by write-protect
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                sel_q <= SEL_W'(DEF_SEL);
        else if (sel_load && !wp)   sel_q <= sel_in;
    end

    // State register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= ST_SUPPLY_HOLD;
        else         state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SUPPLY_HOLD: if (hold_done)       state_d = ST_RUN;
            ST_RUN:         if (!svc && expire)  state_d = ST_WDT_HOLD;
            ST_WDT_HOLD:    if (hold_done)       state_d = ST_RUN;
            default:        state_d = ST_SUPPLY_HOLD;
        endcase
    end

    // Hold interval and watchdog counters
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            hold_cnt_q <= '0;
            wdt_cnt_q  <= '0;
        end else begin
            if (state_d != state_q || state_q == ST_RUN) hold_cnt_q <= '0;
            else                                           hold_cnt_q <= hold_cnt_q + HW'(1);

            if (state_q != ST_RUN || !wdt_en || svc) wdt_cnt_q <= '0;
            else if (!expire)                        wdt_cnt_q <= wdt_cnt_q + CW'(1);
        end
    end

    // Outputs
    always_comb begin
        rst_active = 1'b1;
        unique case (state_q)
            ST_RUN:  rst_active = 1'b0;
            default: rst_active = 1'b1;
        endcase
    end

    p_expire_needs_enable_r4: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_RUN) ##1 (state_q == ST_WDT_HOLD) |-> $past(wdt_en));

    p_disabled_no_expire_r3: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_RUN && !wdt_en) |=> (state_q == ST_RUN));

    p_hold_length_r2: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_RUN) && ($past(state_q) != ST_RUN)
        |-> ($past(hold_cnt_q) == HW'(HOLD_CYCLES - 1)));

    p_service_clears_r5: assert property (@(posedge clk) disable iff (!arst_n)
        (svc && state_q == ST_RUN) |=> (wdt_cnt_q == '0));

    p_restart_zero_r8: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_WDT_HOLD) |=> (wdt_cnt_q == '0));

    p_wp_locks_sel_r7: assert property (@(posedge clk) disable iff (!arst_n)
        wp |=> $stable(sel_q));
endmodule

// File: rtl/bus_wdt_supervisor.sv
`timescale 1ns/1ps
module bus_wdt_supervisor #(
    parameter int HOLD_CYCLES    = 40,
    parameter int TMO_BASE       = 64,
    parameter int TMO_SHIFT      = 1,
    parameter int SEL_W          = 2,
    parameter int DEF_SEL        = 0,
    parameter int SYNC_STAGES    = 2,
    parameter bit RST_ACTIVE_LOW = 1'b1
) (
    input  logic             clk,
    input  logic             supply_ok,
    input  logic             sda_in,
    input  logic             scl_in,
    input  logic             wp,
    input  logic             wdt_en,
    input  logic [SEL_W-1:0] tmo_sel,
    input  logic             tmo_load,
    output logic             rst_out
);
    localparam logic ACT_LVL = RST_ACTIVE_LOW ? 1'b0 : 1'b1;

    logic [1:0] bus_s;
    logic       svc;
    logic       ctrl_rst;
    logic       rst_int;

    bwd_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk    (clk),
        .arst_n (supply_ok),
        .d      ({scl_in, sda_in}),
        .q      (bus_s)
    );

    bwd_seq_detect u_seq (
        .clk    (clk),
        .arst_n (supply_ok),
        .sda_s  (bus_s[0]),
        .scl_s  (bus_s[1]),
        .svc    (svc)
    );

    bwd_ctrl #(
        .HOLD_CYCLES (HOLD_CYCLES),
        .TMO_BASE    (TMO_BASE),
        .TMO_SHIFT   (TMO_SHIFT),
        .SEL_W       (SEL_W),
        .DEF_SEL     (DEF_SEL)
    ) u_ctrl (
        .clk        (clk),
        .arst_n     (supply_ok),
        .wdt_en     (wdt_en),
        .wp         (wp),
        .sel_load   (tmo_load),
        .sel_in     (tmo_sel),
        .svc        (svc),
        .rst_active (ctrl_rst)
    );

    assign rst_int = ~supply_ok | ctrl_rst;

    generate
        if (RST_ACTIVE_LOW) begin : g_low
            assign rst_out = ~rst_int;
        end else begin : g_high
            assign rst_out = rst_int;
        end
    endgenerate

    p_supply_low_r1: assert property (@(posedge clk)
        !supply_ok |-> (rst_out == ACT_LVL));
endmodule

// File: tb/bus_wdt_supervisor_tb.sv
`timescale 1ns/1ps
module bus_wdt_supervisor_tb;
    localparam int HOLD = 40;
    localparam int BASE = 64;

    logic       clk = 1'b0;
    logic       supply_ok = 1'b0;
    logic       sda = 1'b1, scl = 1'b1;
    logic       wp = 1'b0, wdt_en = 1'b0, tmo_load = 1'b0;
    logic [1:0] tmo_sel = 2'd0;
    logic       rst_lo, rst_hi;
    int         n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    bus_wdt_supervisor #(.HOLD_CYCLES(HOLD), .TMO_BASE(BASE), .RST_ACTIVE_LOW(1'b1)) u_dut (
        .clk(clk), .supply_ok(supply_ok), .sda_in(sda), .scl_in(scl), .wp(wp),
        .wdt_en(wdt_en), .tmo_sel(tmo_sel), .tmo_load(tmo_load), .rst_out(rst_lo));

    bus_wdt_supervisor #(.HOLD_CYCLES(HOLD), .TMO_BASE(BASE), .RST_ACTIVE_LOW(1'b0)) u_dut_hi (
        .clk(clk), .supply_ok(supply_ok), .sda_in(sda), .scl_in(scl), .wp(wp),
        .wdt_en(wdt_en), .tmo_sel(tmo_sel), .tmo_load(tmo_load), .rst_out(rst_hi));

    task automatic chk_rst(string req, logic exp_active);
        n_chk++;
        if (rst_lo !== ~exp_active) begin
            n_err++;
            $display("FAIL %s: rst_out=%0b expected %0b at %0t", req, rst_lo, ~exp_active, $time);
        end
        n_chk++;
        if (rst_hi !== exp_active) begin
            n_err++;
            $display("FAIL R9: active-high rst_out=%0b expected %0b at %0t", rst_hi, exp_active, $time);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // Full service sequence; returns on the negedge where the stop edge is driven.
    task automatic kick();
        @(negedge clk) sda = 1'b0;
        wait_n(4); scl = 1'b0;
        wait_n(4); scl = 1'b1;
        wait_n(4); sda = 1'b1;
    endtask

    task automatic t_reset();
        wait_n(5);
        chk_rst("R1 reset state", 1'b1);
    endtask

    task automatic t_powerup();
        @(negedge clk) supply_ok = 1'b1;
        wait_n(HOLD - 3);
        chk_rst("R2 still held", 1'b1);
        wait_n(6);
        chk_rst("R2 released", 1'b0);
    endtask

    task automatic t_disabled();
        wdt_en = 1'b0;
        wait_n(600);
        chk_rst("R3 disabled idle", 1'b0);
    endtask

    task automatic t_service();
        @(negedge clk) wdt_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            kick();
            wait_n(20);
            chk_rst("R5 serviced", 1'b0);
        end
    endtask

    task automatic t_timeout_and_hold();
        kick();
        wait_n(BASE - 3);
        chk_rst("R4 before timeout", 1'b0);
        wait_n(8);
        chk_rst("R4 after timeout", 1'b1);
        wait_n(HOLD - 8);
        chk_rst("R8 hold still active", 1'b1);
        wait_n(6);
        chk_rst("R8 hold released", 1'b0);
        wait_n(BASE - 5);
        chk_rst("R8 restart before second timeout", 1'b0);
        wait_n(8);
        chk_rst("R8 second timeout", 1'b1);
        wdt_en = 1'b0;
        wait_n(HOLD + 5);
        chk_rst("R8 recovered", 1'b0);
    endtask

    task automatic t_partial();
        @(negedge clk) wdt_en = 1'b1;
        kick();
        wait_n(10);
        sda = 1'b0; wait_n(4);          // start then stop without SCL fall
        sda = 1'b1; wait_n(4);
        sda = 1'b0; wait_n(4);          // start and SCL fall, no stop
        scl = 1'b0; wait_n(4);
        scl = 1'b1; wait_n(4);
        wait_n(BASE - 3 - 30);
        chk_rst("R6 partial did not service (before)", 1'b0);
        wait_n(8);
        chk_rst("R6 partial did not service (expired)", 1'b1);
        sda = 1'b1;
        wdt_en = 1'b0;
        wait_n(HOLD + 5);
        chk_rst("R6 recovered", 1'b0);
    endtask

    task automatic t_load();
        @(negedge clk) begin tmo_sel = 2'd2; tmo_load = 1'b1; end
        @(negedge clk) tmo_load = 1'b0;
        wdt_en = 1'b1;
        kick();
        wait_n(4 * BASE - 3);
        chk_rst("R10 longer timeout applied", 1'b0);
        wait_n(8);
        chk_rst("R10 expired at new timeout", 1'b1);
        wdt_en = 1'b0;
        wait_n(HOLD + 5);
    endtask

    task automatic t_wp();
        @(negedge clk) begin wp = 1'b1; tmo_sel = 2'd0; tmo_load = 1'b1; end
        @(negedge clk) begin tmo_load = 1'b0; wp = 1'b0; end
        wdt_en = 1'b1;
        kick();
        wait_n(BASE + 5);
        chk_rst("R7 protected load ignored", 1'b0);
        wait_n(3 * BASE);
        chk_rst("R7 old timeout kept", 1'b1);
        wdt_en = 1'b0;
        wait_n(HOLD + 5);
    endtask

    task automatic t_dip();
        chk_rst("R1 running before dip", 1'b0);
        @(negedge clk) supply_ok = 1'b0;
        #0.5;
        chk_rst("R1 immediate on supply fall", 1'b1);
        wait_n(3);
        @(negedge clk) supply_ok = 1'b1;
        wait_n(HOLD - 3);
        chk_rst("R2 hold after dip", 1'b1);
        wait_n(6);
        chk_rst("R2 release after dip", 1'b0);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_disabled();
        t_service();
        t_timeout_and_hold();
        t_partial();
        t_load();
        t_wp();
        t_dip();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule